// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Sequencer

This block runs exactly one programmed-I/O cycle on a parallel ATA bus for each request it accepts. A request gives the direction, a 5-bit target code and, for a write, a 16-bit word. The target code packs the device register address together with the two active-low chip selects. The sequencer then moves through four phases:

- a setup phase, in which the address and chip selects are driven and both strobes are inactive;
- an active phase, in which the read or write strobe is low;
- an optional wait on the device ready line, bounded by a timeout;
- a recovery phase.

It ends with a one-cycle done pulse. For reads, that pulse comes with the word captured from the bus.

Two timing sets are held on configuration inputs. One is for 8-bit taskfile register access and one is for 16-bit data port access. Each set has a setup count, an active count and a total cycle count. A per-request select bit chooses the set. The recovery length is not programmed separately: it is whatever is left of the total cycle after setup and active. Software above this block is expected to issue one request at a time and wait for done.

Top module: `pio_cycle_seq`

## Requirements
- R1: Out of reset: both chip selects are high (inactive), the address is 0, both strobes are high, the data drive enable is low, busy is low, done is low and the timeout flag is low.
- R2: From the cycle after acceptance until the end of recovery, the pins follow the latched target code. Bit 0 drives chip select 0 (active low), bit 1 drives chip select 1 (active low), and bits 4:2 drive address A2..A0. These pins hold steady for the whole transfer. Taskfile register n uses code (n<<2)+2, and the alternate status/device control register uses code 25.
- R3: The setup phase lasts S clock cycles, where S is the selected setup count, with both strobes high. It begins in the cycle after acceptance.
- R4: The strobe matching the direction (read strobe for req_write=0, write strobe for req_write=1) is low for A cycles, where A is the selected active count. The other strobe stays high, and neither strobe is low outside a transfer.
- R5: Recovery lasts R = total - S - A cycles, or 1 cycle if that value is not positive, with both strobes high. busy covers acceptance through the end of recovery. done is high for exactly one cycle directly after recovery, with busy already low.
- R6: req_wide=1 selects the data-port timing set. req_wide=0 selects the taskfile timing set.
- R7: For a write, the write word is driven with the data drive enable high from the first setup cycle through the end of recovery, so data is present before the strobe falls. For a read, the enable stays low.
- R8: For a read, rd_data takes the bus input value from the last cycle in which the read strobe was low. rd_data keeps that value until the next read completes, and a write leaves it unchanged.
- R9: With ready waiting enabled, if the ready input is low when the active count ends, the strobe stays low until a clock edge sees ready high. Recovery then follows.
- R10: If ready is still low after T wait cycles (T = the timeout limit), the cycle completes normally and the timeout flag sets. It stays set until reset. Ready rising on the last wait cycle counts as ready, not as a timeout.
- R11: A request presented while busy is ignored. The pins keep the current target, and no further cycle follows the current done.
- R12: Any count of zero (setup, active, total or timeout limit) is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wide | input | 1 | 1 = data-port timing set, 0 = taskfile timing set |
| req_target | input | 5 | Target code: A2..A0 in 4:2, chip select 1 in 1, chip select 0 in 0 |
| req_wdata | input | 16 | Word to write |
| tf_setup | input | 8 | Taskfile setup count |
| tf_active | input | 8 | Taskfile active count |
| tf_cycle | input | 8 | Taskfile total cycle count |
| dt_setup | input | 8 | Data-port setup count |
| dt_active | input | 8 | Data-port active count |
| dt_cycle | input | 8 | Data-port total cycle count |
| rdy_en | input | 1 | Enable waiting on the ready line |
| rdy_limit | input | 12 | Ready wait limit in cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last captured read word |
| rdy_timeout | output | 1 | Sticky ready timeout flag |
| bus_cs_n | output | 2 | Chip selects, active low |
| bus_addr | output | 3 | Device register address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Data to the bus |
| bus_doe | output | 1 | Data drive enable |
| bus_din | input | 16 | Data from the bus |
| bus_iordy | input | 1 | Device ready input |

## Verification
The ready input and the expiry of the wait limit can arrive in the same clock. The bench provokes this by raising ready on exactly the last permitted wait cycle. It expects the strobe to have been low for the active count plus the full limit, with the timeout flag still clear; one cycle later the flag would have been set. A second collision is a fresh request arriving while a transfer is still running. The bench judges that case by checking that the address pins do not move and that busy stays low after done.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_ACTIVE = 3'd2,
      PH_WAIT   = 3'd3,
      PH_RECOV  = 3'd4
   } phase_e;

   // bit order is decoded by the bus pins: address high, selects low
   typedef struct packed {
      logic [2:0] addr;
      logic       cs1_n;
      logic       cs0_n;
   } target_t;

endpackage

// File: rtl/pio_span_calc.sv
module pio_span_calc #(
   parameter int CW = 8
) (
   input  logic [CW-1:0] setup_cnt,
   input  logic [CW-1:0] active_cnt,
   input  logic [CW-1:0] cycle_cnt,
   output logic [CW-1:0] setup_len,
   output logic [CW-1:0] active_len,
   output logic [CW-1:0] recov_len
);
   localparam int NF = 3;
   localparam logic [CW-1:0] ONE = CW'(1);

   if (CW < 2) begin : g_bad_width
      $error("pio_span_calc: CW must be at least 2");
   end

   logic [CW-1:0] raw [NF];
   logic [CW-1:0] cl  [NF];

   assign raw[0] = setup_cnt;
   assign raw[1] = active_cnt;
   assign raw[2] = cycle_cnt;

   // zero means one cycle for every programmed count
   for (genvar g = 0; g < NF; g++) begin : g_clamp
      assign cl[g] = (raw[g] == '0) ? ONE : raw[g];
   end

   logic [CW:0] used;
   assign used       = {1'b0, cl[0]} + {1'b0, cl[1]};
   assign setup_len  = cl[0];
   assign active_len = cl[1];

   always_comb begin
      if ({1'b0, cl[2]} > used) recov_len = CW'({1'b0, cl[2]} - used);
      else                      recov_len = ONE;
   end

endmodule

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last
);
   if (W < 2) begin : g_bad_width
      $error("pio_phase_timer: W must be at least 2");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - W'(1);
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
   import pio_seq_pkg::*;
#(
   parameter int DW = 16
) (
   input  phase_e         phase,
   input  target_t        tgt,
   input  logic           is_write,
   input  logic [DW-1:0]  wdata,
   output logic [1:0]     cs_n,
   output logic [2:0]     addr,
   output logic           rd_n,
   output logic           wr_n,
   output logic [DW-1:0]  dout,
   output logic           doe
);
   logic in_xfer, strobe_on;

   assign in_xfer   = (phase != PH_IDLE);
   assign strobe_on = (phase == PH_ACTIVE) || (phase == PH_WAIT);

   always_comb begin
      cs_n = 2'b11;
      addr = '0;
      rd_n = 1'b1;
      wr_n = 1'b1;
      dout = '0;
      doe  = 1'b0;
      if (in_xfer) begin
         cs_n = {tgt.cs1_n, tgt.cs0_n};
         addr = tgt.addr;
         if (is_write) begin
            dout = wdata;
            doe  = 1'b1;
            wr_n = !strobe_on;
         end else begin
            rd_n = !strobe_on;
         end
      end
   end

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
   import pio_seq_pkg::*;
#(
   parameter int CW  = 8,
   parameter int TOW = 12,
   parameter int DW  = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic            req_wide,
   input  logic [4:0]      req_target,
   input  logic [DW-1:0]   req_wdata,
   input  logic [CW-1:0]   tf_setup,
   input  logic [CW-1:0]   tf_active,
   input  logic [CW-1:0]   tf_cycle,
   input  logic [CW-1:0]   dt_setup,
   input  logic [CW-1:0]   dt_active,
   input  logic [CW-1:0]   dt_cycle,
   input  logic            rdy_en,
   input  logic [TOW-1:0]  rdy_limit,
   output logic            busy,
   output logic            done,
   output logic [DW-1:0]   rd_data,
   output logic            rdy_timeout,
   output logic [1:0]      bus_cs_n,
   output logic [2:0]      bus_addr,
   output logic            bus_rd_n,
   output logic            bus_wr_n,
   output logic [DW-1:0]   bus_dout,
   output logic            bus_doe,
   input  logic [DW-1:0]   bus_din,
   input  logic            bus_iordy
);
   localparam int NSET = 2;
   localparam int TW   = (CW > TOW) ? CW : TOW;
   localparam logic [TW-1:0] T_ONE = TW'(1);

   if (CW < 2 || TOW < 2) begin : g_bad_cnt
      $error("pio_cycle_seq: count widths must be at least 2");
   end
   if (DW < 8) begin : g_bad_dw
      $error("pio_cycle_seq: data width must be at least 8");
   end

   // ---------------- timing sets ----------------
   logic [CW-1:0] set_s [NSET];
   logic [CW-1:0] set_a [NSET];
   logic [CW-1:0] set_c [NSET];
   logic [CW-1:0] len_s [NSET];
   logic [CW-1:0] len_a [NSET];
   logic [CW-1:0] len_r [NSET];

   assign set_s[0] = tf_setup;
   assign set_a[0] = tf_active;
   assign set_c[0] = tf_cycle;
   assign set_s[1] = dt_setup;
   assign set_a[1] = dt_active;
   assign set_c[1] = dt_cycle;

   for (genvar k = 0; k < NSET; k++) begin : g_set
      pio_span_calc #(.CW(CW)) u_span (
         .setup_cnt  (set_s[k]),
         .active_cnt (set_a[k]),
         .cycle_cnt  (set_c[k]),
         .setup_len  (len_s[k]),
         .active_len (len_a[k]),
         .recov_len  (len_r[k])
      );
   end

   logic [CW-1:0] pick_s, pick_a, pick_r;
   assign pick_s = req_wide ? len_s[1] : len_s[0];
   assign pick_a = req_wide ? len_a[1] : len_a[0];
   assign pick_r = req_wide ? len_r[1] : len_r[0];

   // ---------------- latched request ----------------
   phase_e         phase, phase_nx;
   target_t        tgt_q;
   logic           wr_q, rdy_en_q;
   logic [DW-1:0]  wdata_q;
   logic [TW-1:0]  a_len_q, r_len_q, t_len_q;

   logic           accept;
   logic           tmr_load, tmr_last;
   logic [TW-1:0]  tmr_val;
   logic           cap_rd, tmo_hit, fin;

   assign accept = req_valid && (phase == PH_IDLE);

   always_comb begin
      phase_nx = phase;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap_rd   = 1'b0;
      tmo_hit  = 1'b0;
      fin      = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (accept) begin
               phase_nx = PH_SETUP;
               tmr_load = 1'b1;
               tmr_val  = TW'(pick_s) - T_ONE;
            end
         end
         PH_SETUP: begin
            if (tmr_last) begin
               phase_nx = PH_ACTIVE;
               tmr_load = 1'b1;
               tmr_val  = a_len_q - T_ONE;
            end
         end
         PH_ACTIVE: begin
            if (tmr_last) begin
               tmr_load = 1'b1;
               if (rdy_en_q && !bus_iordy) begin
                  phase_nx = PH_WAIT;
                  tmr_val  = t_len_q - T_ONE;
               end else begin
                  phase_nx = PH_RECOV;
                  tmr_val  = r_len_q - T_ONE;
                  cap_rd   = 1'b1;
               end
            end
         end
         PH_WAIT: begin
            if (bus_iordy || tmr_last) begin
               phase_nx = PH_RECOV;
               tmr_load = 1'b1;
               tmr_val  = r_len_q - T_ONE;
               cap_rd   = 1'b1;
               tmo_hit  = !bus_iordy;
            end
         end
         PH_RECOV: begin
            if (tmr_last) begin
               phase_nx = PH_IDLE;
               fin      = 1'b1;
            end
         end
         default: phase_nx = PH_IDLE;
      endcase
   end

   pio_phase_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         tgt_q    <= '1;
         wr_q     <= 1'b0;
         rdy_en_q <= 1'b0;
         wdata_q  <= '0;
         a_len_q  <= T_ONE;
         r_len_q  <= T_ONE;
         t_len_q  <= T_ONE;
      end else begin
         phase <= phase_nx;
         if (accept) begin
            tgt_q    <= target_t'(req_target);
            wr_q     <= req_write;
            wdata_q  <= req_wdata;
            rdy_en_q <= rdy_en;
            a_len_q  <= TW'(pick_a);
            r_len_q  <= TW'(pick_r);
            t_len_q  <= (rdy_limit == '0) ? T_ONE : TW'(rdy_limit);
         end
      end
   end

   // ---------------- results ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done        <= 1'b0;
         rd_data     <= '0;
         rdy_timeout <= 1'b0;
      end else begin
         done <= fin;
         if (cap_rd && !wr_q) rd_data <= bus_din;
         if (tmo_hit)         rdy_timeout <= 1'b1;
      end
   end

   assign busy = (phase != PH_IDLE);

   pio_bus_drive #(.DW(DW)) u_drive (
      .phase    (phase),
      .tgt      (tgt_q),
      .is_write (wr_q),
      .wdata    (wdata_q),
      .cs_n     (bus_cs_n),
      .addr     (bus_addr),
      .rd_n     (bus_rd_n),
      .wr_n     (bus_wr_n),
      .dout     (bus_dout),
      .doe      (bus_doe)
   );

   // ---------------- assertions ----------------
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n)); // R4
   AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> busy); // R4
   AST_DATA_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_wr_n) |-> $past(bus_doe)); // R7
   AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_cs_n))); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R5
   AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_timeout |=> rdy_timeout); // R10

endmodule

// File: tb/sim_pio_cycle_seq.sv
`timescale 1ns/100ps
module sim_pio_cycle_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
   logic [4:0]  req_target = '0;
   logic [15:0] req_wdata = '0;
   logic [7:0]  tf_setup = 8'd3, tf_active = 8'd4, tf_cycle = 8'd12;
   logic [7:0]  dt_setup = 8'd1, dt_active = 8'd2, dt_cycle = 8'd4;
   logic        rdy_en = 1'b0;
   logic [11:0] rdy_limit = 12'd6;
   logic        busy, done, rdy_timeout, bus_rd_n, bus_wr_n, bus_doe;
   logic [15:0] rd_data, bus_dout;
   logic [1:0]  bus_cs_n;
   logic [2:0]  bus_addr;
   logic [15:0] bus_din = '0;
   logic        bus_iordy = 1'b0;

   int errors = 0;
   int checks = 0;
   logic [15:0] last_rd = '0;

   always #2.5 clk = ~clk;

   pio_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
      .req_target(req_target), .req_wdata(req_wdata),
      .tf_setup(tf_setup), .tf_active(tf_active), .tf_cycle(tf_cycle),
      .dt_setup(dt_setup), .dt_active(dt_active), .dt_cycle(dt_cycle),
      .rdy_en(rdy_en), .rdy_limit(rdy_limit),
      .busy(busy), .done(done), .rd_data(rd_data), .rdy_timeout(rdy_timeout),
      .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din), .bus_iordy(bus_iordy)
   );

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int cl(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int rec(input int s, input int a, input int c);
      int r;
      r = cl(c) - cl(s) - cl(a);
      return (r > 0) ? r : 1;
   endfunction

   // expected strobe-low length given ready behaviour
   function automatic int low_len(input int a, input bit en, input int t, input int raise_at);
      if (!en || raise_at <= a) return a;
      if (raise_at <= a + cl(t)) return raise_at;
      return a + cl(t);
   endfunction

   task automatic run_cycle(input string tag, input bit wr, input bit wide,
                            input logic [4:0] tgt, input logic [15:0] wd,
                            input int raise_at, input int exp_s, input int exp_low,
                            input int exp_r, input bit exp_tmo, input bit poke,
                            input logic [15:0] din_base);
      int s_cnt = 0, a_cnt = 0, r_cnt = 0, guard = 0;
      bit seen_low = 0, bus_bad = 0, w_bad = 0;
      logic [15:0] exp_rd;
      @(negedge clk);
      bus_iordy  = (raise_at == 0);
      req_write  = wr;
      req_wide   = wide;
      req_target = tgt;
      req_wdata  = wd;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && guard < 5000) begin
         guard++;
         if (busy) begin
            if (bus_cs_n != tgt[1:0] || bus_addr != tgt[4:2]) bus_bad = 1;
            if (wr ? !bus_rd_n : !bus_wr_n) bus_bad = 1;
            if (wr && (!bus_doe || bus_dout != wd)) w_bad = 1;
            if (!wr && bus_doe) w_bad = 1;
            if (!bus_rd_n || !bus_wr_n) begin
               a_cnt++;
               seen_low = 1;
               bus_din = din_base + 16'(a_cnt);
               if (a_cnt == raise_at) bus_iordy = 1'b1;
            end else if (!seen_low) s_cnt++;
            else r_cnt++;
         end else bus_bad = 1;
         if (poke && s_cnt == 1 && a_cnt == 0) begin
            req_valid  = 1'b1;
            req_target = ~tgt;
         end else req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      exp_rd = wr ? last_rd : din_base + 16'(exp_low);
      chk({tag, " R2 target pins and strobe choice"}, int'(bus_bad), 0);
      chk({tag, " R3 setup cycles"}, s_cnt, exp_s);
      chk({tag, " R4/R9 strobe-low cycles"}, a_cnt, exp_low);
      chk({tag, " R5 recovery cycles"}, r_cnt, exp_r);
      chk({tag, " R5 done with busy low"}, int'({done, busy}), 2);
      chk({tag, " R7 data drive"}, int'(w_bad), 0);
      chk({tag, " R8 read word"}, int'(rd_data), int'(exp_rd));
      chk({tag, " R10 timeout flag"}, int'(rdy_timeout), int'(exp_tmo));
      last_rd = exp_rd;
      bus_iordy = 1'b0;
      @(negedge clk);
      chk({tag, " R5 done lasts one cycle"}, int'(done), 0);
      if (poke) chk({tag, " R11 request while busy ignored"}, int'(busy), 0);
   endtask

   task automatic t_reset;
      chk("R1 chip selects", int'(bus_cs_n), 3);
      chk("R1 strobes", int'({bus_rd_n, bus_wr_n}), 3);
      chk("R1 busy/done/timeout/doe", int'({busy, done, rdy_timeout, bus_doe}), 0);
      chk("R1 address", int'(bus_addr), 0);
   endtask

   task automatic t_read_taskfile; // R6 taskfile set, register 7
      run_cycle("taskfile read R6", 0, 0, 5'((7 << 2) + 2), 16'h0, 999,
                cl(3), low_len(4, 0, 6, 999), rec(3, 4, 12), 0, 0, 16'h1200);
   endtask

   task automatic t_write_data; // R6 data set, data register
      run_cycle("data write R6", 1, 1, 5'd2, 16'hA55A, 999,
                cl(1), low_len(2, 0, 6, 999), rec(1, 2, 4), 0, 0, 16'h0);
   endtask

   task automatic t_recov_floor; // R5 total shorter than setup+active
      tf_cycle = 8'd5;
      run_cycle("recovery floor R5", 1, 0, 5'((1 << 2) + 2), 16'h00C3, 999,
                3, 4, rec(3, 4, 5), 0, 0, 16'h0);
      tf_cycle = 8'd12;
   endtask

   task automatic t_zero_counts; // R12 all-zero data set, alt status code 25
      dt_setup = 0; dt_active = 0; dt_cycle = 0;
      run_cycle("zero counts R12", 0, 1, 5'd25, 16'h0, 999,
                cl(0), cl(0), rec(0, 0, 0), 0, 0, 16'h3400);
      dt_setup = 8'd1; dt_active = 8'd2; dt_cycle = 8'd4;
   endtask

   task automatic t_rdy_stretch; // R9
      rdy_en = 1'b1; rdy_limit = 12'd6;
      run_cycle("ready stretch R9", 0, 0, 5'd30, 16'h0, 7,
                3, low_len(4, 1, 6, 7), 5, 0, 0, 16'h5000);
      run_cycle("ready already high R9", 0, 0, 5'd30, 16'h0, 0,
                3, low_len(4, 1, 6, 0), 5, 0, 0, 16'h5100);
   endtask

   task automatic t_rdy_edge; // R10 ready on last permitted wait cycle
      run_cycle("ready at limit R10", 0, 0, 5'd30, 16'h0, 10,
                3, low_len(4, 1, 6, 10), 5, 0, 0, 16'h6000);
   endtask

   task automatic t_timeout; // R10
      run_cycle("timeout R10", 0, 0, 5'd30, 16'h0, 999,
                3, low_len(4, 1, 6, 999), 5, 1, 0, 16'h7000);
      rdy_en = 1'b0;
      run_cycle("sticky flag R10", 1, 1, 5'd2, 16'h1234, 999,
                1, 2, 1, 1, 0, 16'h0);
   endtask

   task automatic t_busy_ignore; // R11
      run_cycle("busy ignore R11", 0, 0, 5'((3 << 2) + 2), 16'h0, 999,
                3, 4, 5, 1, 1, 16'h0800);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_read_taskfile();
      t_write_data();
      t_recov_floor();
      t_zero_counts();
      t_rdy_stretch();
      t_rdy_edge();
      t_timeout();
      t_busy_ignore();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5ns * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule